// File: doc/BRIEF.md
# Interrupt Request Status Aggregator

This block gathers level-sensitive interrupt requests from the baseboard and option devices. It reports them to software in two ways. The first is a read-only status word: seven device requests sit at fixed positions in the low half of a 32-bit word, which a simple strobe-driven read port returns. The second is a set of six CPU hardware interrupt lines. Some lines carry one source each, and others combine several sources with an OR.

The block has no mask register. When a CPU line fires, the handler reads the status word to find which device is asking. A request stays visible for as long as the device holds it; the block never acknowledges or clears anything. Every request passes through a two-flop synchroniser before it affects any output. The CPU lines add one registered stage after the synchroniser.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, `cpu_irq` is 6'b0 and `rd_data` is 32'h0.
- R2: In a captured status word, bit 14 is the reset button, bit 13 the memory write error, bit 12 the network controller, bit 11 the SCSI controller, bit 10 the second option serial card, bit 9 the first option serial card and bit 8 the baseboard serial controller; a 1 means the request is asserted.
- R3: Status bits 31:15 and 7:0 always read as 0, and the FPU and clock requests never appear in the status word.
- R4: `cpu_irq[5]` follows the FPU request, `cpu_irq[4]` the reset button, `cpu_irq[3]` the memory write error and `cpu_irq[2]` the clock request.
- R5: `cpu_irq[1]` is the OR of the SCSI and network requests.
- R6: `cpu_irq[0]` is the OR of the baseboard serial request and both option serial card requests.
- R7: A change on a request input reaches `cpu_irq` on the third rising clock edge after the change, and not before.
- R8: `rd_data` loads on a rising edge where `rd_en` is 1, using the synchronised request values present in that cycle. It holds its value at every other edge, whatever the requests do.
- R9: Every asserted source appears at the same time, with no masking, so several simultaneous requests all show in the status word and on their lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_fpu | input | 1 | FPU interrupt request |
| req_tick | input | 1 | Clock interrupt request |
| req_rst_btn | input | 1 | Reset button request |
| req_wr_err | input | 1 | Memory write error request |
| req_net | input | 1 | Network controller request |
| req_scsi | input | 1 | SCSI controller request |
| req_opt1 | input | 1 | Second option serial card request |
| req_opt0 | input | 1 | First option serial card request |
| req_ser | input | 1 | Baseboard serial controller request |
| rd_en | input | 1 | Read strobe for the status word |
| rd_data | output | 32 | Captured status word |
| cpu_irq | output | 6 | CPU hardware interrupt lines |

## Verification
The assertions check three rules on every cycle once the pipeline has filled. Each CPU line must equal its source or its OR group as the inputs stood three edges earlier. A read must capture the same delayed request pattern. Between strobes, `rd_data` must stay unchanged. The bench covers what the assertions do not. Its scenarios show the reset values and show that a line stays low until the third edge after a change. They also show that the zero fields and the excluded FPU and clock sources stay out of the word under random request mixes. Finally, they show that a word already captured ignores later request activity.

// File: rtl/irq_status_agg.sv
module irq_status_agg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fpu,
  input  logic        req_tick,
  input  logic        req_rst_btn,
  input  logic        req_wr_err,
  input  logic        req_net,
  input  logic        req_scsi,
  input  logic        req_opt1,
  input  logic        req_opt0,
  input  logic        req_ser,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic [5:0]  cpu_irq
);

  logic [8:0] raw, meta, sync;
  logic [5:0] grouped;
  logic [15:0] status_lo;

  assign raw = {req_fpu, req_tick, req_rst_btn, req_wr_err, req_net,
                req_scsi, req_opt1, req_opt0, req_ser};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= raw;
      sync <= meta;
    end
  end

  assign status_lo = {1'b0, sync[6:0], 8'h00};

  assign grouped = {sync[8], sync[6], sync[5], sync[7],
                    sync[4] | sync[3],
                    sync[2] | sync[1] | sync[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq <= '0;
      rd_data <= '0;
    end else begin
      cpu_irq <= grouped;
      if (rd_en) rd_data <= {16'h0000, status_lo};
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_DIRECT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> cpu_irq[5:2] == $past({req_fpu, req_rst_btn, req_wr_err, req_tick}, 3)); // R4
  AST_LINE1_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> cpu_irq[1] == $past(req_net || req_scsi, 3)); // R5
  AST_LINE0_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> cpu_irq[0] == $past(req_ser || req_opt0 || req_opt1, 3)); // R6
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) && $past(rd_en) |-> rd_data[14:8] ==
      $past({req_rst_btn, req_wr_err, req_net, req_scsi, req_opt1, req_opt0, req_ser}, 3)); // R2
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8

endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] v = '0;
  logic rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [5:0] cpu_irq;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // v: [8]fpu [7]tick [6]rst_btn [5]wr_err [4]net [3]scsi [2]opt1 [1]opt0 [0]ser
  irq_status_agg i_irq_status_agg (
    .clk(clk), .rst_n(rst_n),
    .req_fpu(v[8]), .req_tick(v[7]), .req_rst_btn(v[6]), .req_wr_err(v[5]),
    .req_net(v[4]), .req_scsi(v[3]), .req_opt1(v[2]), .req_opt0(v[1]),
    .req_ser(v[0]), .rd_en(rd_en), .rd_data(rd_data), .cpu_irq(cpu_irq));

  function automatic logic [5:0] exp_lines(logic [8:0] x);
    logic fpu, tick, rb, we, net, scsi, o1, o0, ser;
    {fpu, tick, rb, we, net, scsi, o1, o0, ser} = x;
    return {fpu, rb, we, tick, net | scsi, ser | o0 | o1};
  endfunction

  function automatic logic [31:0] exp_word(logic [8:0] x);
    logic [31:0] w = '0;
    w[14] = x[6]; w[13] = x[5]; w[12] = x[4]; w[11] = x[3];
    w[10] = x[2]; w[9] = x[1]; w[8] = x[0];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(logic [8:0] x);
    @(negedge clk); v = x;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 lines", {26'h0, cpu_irq}, 32'h0);
    check("R1 word", rd_data, 32'h0);
    rst_n = 1'b1;

    // R7 latency on the network line
    @(negedge clk); v = 9'h010;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 before third edge", {31'h0, cpu_irq[1]}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 at third edge", {31'h0, cpu_irq[1]}, 32'h1);

    // R3 fpu and tick excluded from the word
    settle(9'h180);
    check("R4 fpu/tick lines", {26'h0, cpu_irq}, {26'h0, exp_lines(9'h180)});
    do_read();
    check("R3 fpu/tick absent", rd_data, 32'h0);

    // R9 every source at once
    settle(9'h1FF);
    do_read();
    check("R9 all word", rd_data, 32'h00007F00);
    check("R9 all lines", {26'h0, cpu_irq}, 32'h3F);

    // R5 / R6 single members of each group
    settle(9'h008);
    check("R5 scsi only", {26'h0, cpu_irq}, 32'h02);
    settle(9'h004);
    check("R6 opt1 only", {26'h0, cpu_irq}, 32'h01);
    settle(9'h002);
    check("R6 opt0 only", {26'h0, cpu_irq}, 32'h01);

    // R2 walking one through the status bits
    for (int b = 0; b < 7; b++) begin
      settle(9'h001 << b);
      do_read();
      check("R2 walking bit", rd_data, 32'h100 << b);
    end

    // random mixes
    for (int i = 0; i < 60; i++) begin
      logic [8:0] x, y;
      x = 9'($urandom);
      y = 9'($urandom);
      settle(x);
      check("R4/R5/R6 random lines", {26'h0, cpu_irq}, {26'h0, exp_lines(x)});
      do_read();
      check("R2/R3 random word", rd_data, exp_word(x));
      settle(y);
      check("R8 word held without strobe", rd_data, exp_word(x));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule